// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a single-port synchronous SRAM with registered reads and a short linear burst. Each word holds two 9-bit lanes (eight data bits plus one parity bit per lane). Every control input is sampled on the rising clock edge. A short set of three chip selects, two address strobes, an advance input and the write enables decides, on each edge, whether the array is read, written, or left alone.

An access opened by a strobe loads the full address. The two low address bits seed a 2-bit burst offset. The offset then steps by one on each edge where advance is low, and it wraps modulo 4 while the upper bits stay put. When advance is high the access repeats at the same address. Read data leaves through a single output register, one edge after the address was taken. An asynchronous active-low output enable gates the pad-enable signal. That enable is forced off for the first read that follows a deselect.

The default depth is 1K words (`ADDR_W` = 10). A 128K-word instance uses `ADDR_W` = 17. The sleep input only blocks new accesses and leaves stored data untouched.

Top module: `burst_sram`

## Requirements
- R1: An access opens only on an edge where a strobe is taken and `cs_a_n`=0, `cs_b`=1, `cs_c_n`=0. A taken strobe with any other select pattern closes the current access. While closed, edges without a strobe neither read nor write.
- R2: A strobe that opens an access uses the full `addr` bus for that edge's access and keeps `addr[ADDR_W-1:2]` as the burst base.
- R3: If both strobes are low while `cs_a_n`=0, the processor strobe wins and the access is a read, whatever the write enables are. While `cs_a_n`=1, `cpu_strb_n` is ignored.
- R4: On an edge with no taken strobe, `burst_adv_n`=0 and an open access, the two low address bits step by +1 modulo 4 (3 wraps to 0) and the upper bits are unchanged.
- R5: On an edge with no taken strobe, `burst_adv_n`=1 and an open access, the access repeats at the previous address.
- R6: On an access edge that is not opened by the processor strobe, `wr_all_n`=0 writes both lanes from `wdata`.
- R7: With `wr_all_n`=1, lane i (bits `[9*i+8:9*i]`, lane 0 lowest) is written only if `wr_byte_n`=0 and `lane_wr_n[i]`=0. An access edge with no lane enabled is a read.
- R8: A read taken on one edge presents the stored word on `rdata` after that edge and holds it until the next read.
- R9: `rdata_oe` is high only while a read's data is on `rdata` and `out_en_n` is low. It follows `out_en_n` without a clock.
- R10: For a read that opens an access while no access was open, `rdata_oe` stays low during its data cycle whatever `out_en_n` is.
- R11: While `sleep`=1, no edge reads, writes or loads an address. Stored words and the open burst are kept, and `rdata_oe` is low after such an edge.
- R12: After synchronous reset no access is open and `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address |
| cs_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| cs_b | input | 1 | Chip select B, active high |
| cs_c_n | input | 1 | Chip select C, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write both lanes, active low |
| wr_byte_n | input | 1 | Enable per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Blocks accesses while high |
| wdata | input | 9*LANES | Write data |
| rdata | output | 9*LANES | Registered read data |
| rdata_oe | output | 1 | Pad drive enable for `rdata` |

## Verification
Several controls can compete on a single edge. A strobe can arrive together with a low advance. Both strobes can be low while the write enables request a full write. A strobe or an advance can arrive while sleep is high. The bench drives each of these collisions on purpose and follows every edge with a read of the affected word. That read is checked against a reference array that applies only the winning action: strobe over advance, the processor strobe as a read over the controller write, and sleep over everything. The next edge after each collision is also checked for the expected `rdata_oe` value, which shows whether the masked first-read rule applied.

// File: rtl/bsram_pkg.sv
// Shared types for the burst SRAM.
// Assumes each lane is 8 data bits plus one parity bit.
package bsram_pkg;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_t;
endpackage

// File: rtl/bsram_burst_ctr.sv
// Burst offset counter: loads a start offset, steps by one with natural
// wrap, or holds. Assumes the caller raises upd only on access edges.
module bsram_burst_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             upd,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    // Offset used by this edge's access.
    always_comb begin
        if (load)      cnt_nxt = load_val;
        else if (step) cnt_nxt = cnt_q + 1'b1;
        else           cnt_nxt = cnt_q;
    end

    // Keep the offset of the last access.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (upd) cnt_q <= cnt_nxt;
    end

    assert_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !load && step) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/bsram_ctrl.sv
// Access decode: chip select, strobe priority, burst continuation, sleep
// gating and lane write enables. Produces one access per edge at most.
// Assumes ADDR_W > 2 (two low bits form the burst offset).
module bsram_ctrl import bsram_pkg::*; #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_a_n,
    input  logic              cs_b,
    input  logic              cs_c_n,
    input  logic              cpu_strb_n,
    input  logic              ctl_strb_n,
    input  logic              burst_adv_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              sleep,
    output acc_t              acc,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  lane_en,
    output logic              first_rd
);
    localparam int CNT_W = 2;
    localparam int HI_W  = ADDR_W - CNT_W;

    logic            chip_sel, cpu_take, ctl_take, strobe, start, resume, wr_req;
    logic            active_q;
    logic [HI_W-1:0] hi_q;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    // Decode selects, strobes and which action wins this edge.
    always_comb begin
        chip_sel = !cs_a_n && cs_b && !cs_c_n;
        cpu_take = !cpu_strb_n && !cs_a_n;
        ctl_take = !ctl_strb_n && !cpu_take;
        strobe   = !sleep && (cpu_take || ctl_take);
        start    = strobe && chip_sel;
        resume   = !sleep && !strobe && active_q;
    end

    // Lane write enables from the global and per-lane controls.
    always_comb begin
        if (!wr_all_n)      lane_en = '1;
        else if (!wr_byte_n) lane_en = ~lane_wr_n;
        else                lane_en = '0;
        wr_req = |lane_en;
    end

    // Kind of access: the processor strobe always opens with a read.
    always_comb begin
        if (start)       acc = (cpu_take || !wr_req) ? ACC_READ : ACC_WRITE;
        else if (resume) acc = wr_req ? ACC_WRITE : ACC_READ;
        else             acc = ACC_IDLE;
        first_rd = start && !active_q;
    end

    bsram_burst_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .step     (resume && !burst_adv_n),
        .upd      (start || resume),
        .load_val (addr[CNT_W-1:0]),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt)
    );

    // Address for this edge: fresh on a start, base plus offset otherwise.
    always_comb begin
        acc_addr = {(start ? addr[ADDR_W-1:CNT_W] : hi_q), cnt_nxt};
    end

    // Track whether an access is open and hold the burst base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            hi_q     <= '0;
        end else if (strobe) begin
            active_q <= chip_sel;
            if (chip_sel) hi_q <= addr[ADDR_W-1:CNT_W];
        end
    end

    assert_sleep_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (acc == ACC_IDLE));

    assert_cpu_strobe_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strb_n && !cs_a_n) |-> (acc != ACC_WRITE));

    assert_closed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !(cs_b && !cs_c_n && !cs_a_n)) |-> (acc == ACC_IDLE));

    assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (acc_addr == addr));

    assert_base_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resume && !burst_adv_n) |-> (acc_addr[ADDR_W-1:CNT_W] == hi_q));
endmodule

// File: rtl/bsram_lane.sv
// One 9-bit lane of storage with a registered read port.
// Assumes read and write never hit the same edge (decode guarantees it).
module bsram_lane #(
    parameter int ADDR_W = 10,
    parameter int W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] mem [DEPTH];

    // Store the lane when its write enable is set; contents are not reset.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Read register: captures the addressed word on a read edge.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (re) rdata_q <= mem[addr];
    end
endmodule

// File: rtl/bsram_rdpipe.sv
// Output-enable stage: tracks which cycle carries read data, masks the
// first read after a deselect, and applies the asynchronous enable.
module bsram_rdpipe (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue,
    input  logic mask_in,
    input  logic out_en_n,
    output logic rdata_oe
);
    logic valid_q, mask_q;

    // Remember whether the previous edge read, and whether to mask it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            mask_q  <= 1'b0;
        end else begin
            valid_q <= rd_issue;
            mask_q  <= rd_issue && mask_in;
        end
    end

    // Pad enable follows out_en_n without a clock.
    always_comb rdata_oe = valid_q && !mask_q && !out_en_n;

    assert_mask_implies_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> valid_q);
endmodule

// File: rtl/burst_sram.sv
// Top of the pipelined burst SRAM: control decode, per-lane storage and
// output stage. Assumes the data bus is split into in, out and enable.
module burst_sram import bsram_pkg::*; #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     cs_a_n,
    input  logic                     cs_b,
    input  logic                     cs_c_n,
    input  logic                     cpu_strb_n,
    input  logic                     ctl_strb_n,
    input  logic                     burst_adv_n,
    input  logic                     wr_all_n,
    input  logic                     wr_byte_n,
    input  logic [LANES-1:0]         lane_wr_n,
    input  logic                     out_en_n,
    input  logic                     sleep,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rdata_oe
);
    acc_t              acc;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  lane_en;
    logic              first_rd, rd_issue, wr_issue;

    bsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .cs_a_n      (cs_a_n),
        .cs_b        (cs_b),
        .cs_c_n      (cs_c_n),
        .cpu_strb_n  (cpu_strb_n),
        .ctl_strb_n  (ctl_strb_n),
        .burst_adv_n (burst_adv_n),
        .wr_all_n    (wr_all_n),
        .wr_byte_n   (wr_byte_n),
        .lane_wr_n   (lane_wr_n),
        .sleep       (sleep),
        .acc         (acc),
        .acc_addr    (acc_addr),
        .lane_en     (lane_en),
        .first_rd    (first_rd)
    );

    // Split the access kind into read and write strobes.
    always_comb begin
        rd_issue = (acc == ACC_READ);
        wr_issue = (acc == ACC_WRITE);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bsram_lane #(.ADDR_W(ADDR_W), .W(LANE_W)) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_issue && lane_en[g]),
            .re      (rd_issue),
            .addr    (acc_addr),
            .wdata   (wdata[g*LANE_W +: LANE_W]),
            .rdata_q (rdata[g*LANE_W +: LANE_W])
        );
    end

    bsram_rdpipe i_rdpipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (rd_issue),
        .mask_in  (first_rd),
        .out_en_n (out_en_n),
        .rdata_oe (rdata_oe)
    );

    assert_first_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && first_rd) |=> !rdata_oe);

    assert_sleep_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rdata_oe);

    assert_write_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue |=> !rdata_oe);
endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;
    localparam int AW = 10;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic cs_a_n = 1, cs_b = 0, cs_c_n = 1, cpu_strb_n = 1, ctl_strb_n = 1;
    logic burst_adv_n = 1, wr_all_n = 1, wr_byte_n = 1, out_en_n = 1, sleep = 0;
    logic [1:0]    lane_wr_n = 2'b11;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    always #4 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(2)) i_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_a_n(cs_a_n), .cs_b(cs_b),
        .cs_c_n(cs_c_n), .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
        .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .sleep(sleep),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    typedef struct {
        bit            rd;
        logic [DW-1:0] data;
        bit            oe;
        string         tag;
    } item_t;

    item_t         sb[$];
    int            n_chk = 0;
    int            n_bad = 0;
    bit            m_act = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] ref_mem [1 << AW];

    // Driver: applies one edge of stimulus and queues the expected result.
    task automatic step(input logic [AW-1:0] a, input bit s1n, s2, s3n, pn, cn,
                        advn, gwn, bwen, input bit [1:0] bwn, input bit oen, zz,
                        input logic [DW-1:0] d, input string tag);
        bit sel, p, c, st, go, wr, msk;
        bit [1:0] en;
        logic [AW-1:0] ea;
        item_t it;
        @(negedge clk);
        addr = a; cs_a_n = s1n; cs_b = s2; cs_c_n = s3n; cpu_strb_n = pn;
        ctl_strb_n = cn; burst_adv_n = advn; wr_all_n = gwn; wr_byte_n = bwen;
        lane_wr_n = bwn; out_en_n = oen; sleep = zz; wdata = d;
        sel = !s1n && s2 && !s3n;
        p   = !pn && !s1n;
        c   = !cn && !p;
        st  = !zz && (p || c);
        en  = !gwn ? 2'b11 : (!bwen ? ~bwn : 2'b00);
        go = 0; wr = 0; msk = 0; ea = '0;
        if (st && sel) begin
            ea = a; msk = !m_act; m_act = 1; go = 1; wr = c && (en != 0);
        end else if (st) begin
            m_act = 0;
        end else if (!zz && m_act) begin
            ea = advn ? m_addr : {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
            go = 1; wr = (en != 0);
        end
        it.rd = 0; it.data = '0; it.oe = 0; it.tag = tag;
        if (go) begin
            m_addr = ea;
            if (wr) begin
                if (en[0]) ref_mem[ea][8:0]  = d[8:0];
                if (en[1]) ref_mem[ea][17:9] = d[17:9];
            end else begin
                it.rd = 1; it.data = ref_mem[ea]; it.oe = !msk && !oen;
            end
        end
        sb.push_back(it);
    endtask

    task automatic wr_c(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        step(a, 0, 1, 0, 1, 0, 1, 0, 1, 2'b11, 0, 0, d, tag);
    endtask
    task automatic rd_p(input logic [AW-1:0] a, input bit oen, input string tag);
        step(a, 0, 1, 0, 0, 1, 1, 1, 1, 2'b11, oen, 0, '0, tag);
    endtask
    task automatic adv(input bit gwn, bwen, input bit [1:0] bwn, input logic [DW-1:0] d,
                       input string tag);
        step('0, 1, 1, 0, 1, 1, 0, gwn, bwen, bwn, 0, 0, d, tag);
    endtask
    task automatic hold(input bit oen, input string tag);
        step('0, 1, 1, 0, 1, 1, 1, 1, 1, 2'b11, oen, 0, '0, tag);
    endtask
    task automatic desel(input string tag);
        step('0, 0, 0, 0, 1, 0, 1, 1, 1, 2'b11, 0, 0, '0, tag);
    endtask

    // Monitor: pops one expectation per edge and compares, away from the edge.
    always @(posedge clk) begin
        item_t it;
        #2;
        if (sb.size() != 0) begin
            it = sb.pop_front();
            n_chk++;
            if (rdata_oe !== it.oe) begin
                n_bad++;
                $display("FAIL %s rdata_oe actual=%0b expected=%0b", it.tag, rdata_oe, it.oe);
            end
            if (it.rd && !$isunknown(it.data)) begin
                n_chk++;
                if (rdata !== it.data) begin
                    n_bad++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata, it.data);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 'x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        out_en_n = 1'b0;
        @(posedge clk); #2;
        n_chk++;  // R12: idle after reset
        if (rdata_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 rdata_oe actual=%0b expected=0", rdata_oe);
        end

        for (int i = 0; i < 16; i++) wr_c(AW'(i), DW'(18'h01000 + i * 37), "R6");
        desel("R1"); desel("R1");
        adv(1, 1, 2'b11, '0, "R1");          // closed: advance does nothing
        rd_p(10'd6, 0, "R10");               // opens from closed: masked
        adv(1, 1, 2'b11, '0, "R4");          // 7
        adv(1, 1, 2'b11, '0, "R4");          // wraps to 4
        hold(0, "R5");                       // stays at 4
        adv(1, 1, 2'b11, '0, "R4");          // 5
        rd_p(10'd9, 0, "R8");
        rd_p(10'd9, 1, "R9");                // enable high: no drive
        step(10'd9, 0, 1, 0, 0, 0, 1, 0, 1, 2'b11, 0, 0, 18'h3ffff, "R3");
        rd_p(10'd9, 0, "R3");
        step(10'd12, 1, 1, 0, 0, 1, 1, 1, 1, 2'b11, 0, 0, '0, "R3");   // ignored strobe
        step(10'd3, 0, 1, 1, 1, 0, 1, 1, 1, 2'b11, 0, 0, '0, "R1");    // deselect
        hold(0, "R1");
        rd_p(10'd3, 0, "R10");

        wr_c(10'd20, 18'h2aaaa, "R6");
        step(10'd20, 0, 1, 0, 1, 0, 1, 1, 0, 2'b10, 0, 0, 18'h15555, "R7");
        step(10'd20, 0, 1, 0, 1, 0, 1, 1, 0, 2'b01, 0, 0, 18'h0ff00, "R7");
        step(10'd20, 0, 1, 0, 1, 0, 1, 1, 1, 2'b00, 0, 0, 18'h3ffff, "R7");
        rd_p(10'd20, 0, "R7");

        wr_c(10'd30, 18'h11111, "R4");
        adv(0, 1, 2'b11, 18'h22222, "R4");   // 31
        adv(0, 1, 2'b11, 18'h33333, "R4");   // 28
        adv(1, 0, 2'b01, 18'h3ffff, "R7");   // 29, lane 1 only
        rd_p(10'd28, 0, "R4");
        adv(1, 1, 2'b11, '0, "R4");
        adv(1, 1, 2'b11, '0, "R4");
        adv(1, 1, 2'b11, '0, "R4");
        adv(1, 1, 2'b11, '0, "R4");

        wr_c(10'd40, 18'h0abcd, "R6");
        step(10'd40, 0, 1, 0, 1, 0, 1, 0, 1, 2'b11, 0, 1, 18'h12345, "R11");
        step('0, 1, 1, 0, 1, 1, 0, 1, 1, 2'b11, 0, 1, '0, "R11");
        rd_p(10'd40, 0, "R11");

        for (int i = 512; i < 516; i++) wr_c(AW'(i), DW'(18'h20000 + i), "R2");
        rd_p(10'd515, 0, "R2");
        adv(1, 1, 2'b11, '0, "R4");          // wraps to 512
        desel("R1");
        hold(0, "R1");

        repeat (3) @(posedge clk);
        #3;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule